// File: doc/BRIEF.md
# Scoreboard Issue and Hazard Controller

This block is the central scoreboard for a small group of pipelined floating-point units. Decoded instructions arrive one at a time, in program order, as an operation code, a destination register and two source registers. For each one the block picks a functional unit, records the instruction in that unit's status record, and then walks it through four ordered steps: issue, operand read, execution and result write. It grants each step only when that step is free of hazards. The arithmetic is not modelled here. Each unit's execution is a latency counter, and the block's grant outputs are the start and write strobes a datapath would follow.

Every unit record holds a busy bit, the operation, the destination and both source register numbers. It also holds, for each source, the tag of the unit that will produce it and a flag meaning "ready and not yet read". A per-register table names the unit that will next write each register. Issue stalls on a busy unit class or a pending writer of the same destination. The operand read waits for both sources. The result write waits while any older reader still needs the old value. Operand reads and result writes per cycle are capped at the number of buses, and the oldest instruction wins a contended bus.

Top module: `sb_ctrl`

## Requirements
- R1: After reset every unit is idle: `iss_ready` is 1 and `rd_grant` and `wb_grant` are all zero.
- R2: Operation codes map to units as follows: 0 (load/integer) to unit 0; 1 (add) and 2 (subtract) to unit 3; 3 (multiply) to unit 1, or to unit 2 when unit 1 is busy; 4 (divide) to unit 4. `iss_unit` shows the chosen unit in the cycle the issue is accepted (`iss_valid` and `iss_ready` both high).
- R3: For an instruction with no hazards, the unit's `wb_grant` bit rises LAT+2 cycles after the cycle it is accepted. LAT is 1 for load, 2 for add and subtract, 10 for multiply and 40 for divide.
- R4: `iss_ready` is low while every unit of the needed class is busy. This includes a unit that is writing its result in that same cycle, so the stalled instruction is accepted in the cycle after that write.
- R5: `iss_ready` is low while the destination register has a pending writer (WAW). The stalled instruction is accepted in the cycle after that writer's `wb_grant`.
- R6: A unit gets `rd_grant` only when both of its sources are ready. A source produced by another unit becomes ready in the cycle after that unit's `wb_grant`.
- R7: A unit's result write is held while another busy unit has that destination as a source that is ready but not yet read (WAR). It is released in the cycle after that unit's `rd_grant`.
- R8: No more than RD_BUSES bits of `rd_grant` and WR_BUSES bits of `wb_grant` are high in any cycle. When requests contend, the earliest-issued instruction is granted first, whatever its unit index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| iss_valid | input | 1 | A decoded instruction is presented |
| iss_op | input | 3 | Operation code (0 load, 1 add, 2 sub, 3 mul, 4 div) |
| iss_dst | input | 5 | Destination register number |
| iss_src1 | input | 5 | First source register number |
| iss_src2 | input | 5 | Second source register number |
| iss_ready | output | 1 | Instruction can be accepted this cycle |
| iss_unit | output | 3 | Unit chosen for the presented instruction |
| rd_grant | output | 5 | Per-unit operand read grant (execution start) |
| wb_grant | output | 5 | Per-unit result write grant |

## Verification
A wrong producer tag or ready flag shows up at the ports as a `rd_grant` that comes a cycle early or never comes. This is visible the cycle after the producer's `wb_grant`. A stale register-status entry or busy bit shows as `iss_ready` staying low after the writer has finished, so the next dependent issue is late by a whole latency. A bad age comparison shows as the wrong unit winning a contended read in the very first contested cycle. The bench therefore measures exact cycle distances between issue, read and write events rather than only their order.

// File: rtl/sb_pkg.sv
package sb_pkg;
    localparam int NFU  = 5;
    localparam int NREG = 32;
    localparam int RW   = $clog2(NREG);
    localparam int UW   = $clog2(NFU);
    localparam int SEQW = UW + 1;

    typedef logic [RW-1:0] reg_t;
    typedef logic [UW-1:0] fu_t;

    typedef enum logic [2:0] {OP_LOAD, OP_ADD, OP_SUB, OP_MUL, OP_DIV} op_t;
    typedef enum logic [1:0] {K_INT, K_MUL, K_ADD, K_DIV} kind_t;
    typedef enum logic [1:0] {ST_READ, ST_EXEC, ST_WRITE} stage_t;

    typedef struct packed {
        logic busy;
        op_t  op;
        reg_t fi;
        reg_t fj;
        reg_t fk;
        fu_t  qj;
        fu_t  qk;
        logic qjv;
        logic qkv;
        logic rj;
        logic rk;
    } fu_rec_t;

    function automatic kind_t op_kind(op_t op);
        case (op)
            OP_ADD, OP_SUB: return K_ADD;
            OP_MUL:         return K_MUL;
            OP_DIV:         return K_DIV;
            default:        return K_INT;
        endcase
    endfunction

    function automatic kind_t unit_kind(int u);
        case (u)
            0:       return K_INT;
            1, 2:    return K_MUL;
            3:       return K_ADD;
            default: return K_DIV;
        endcase
    endfunction
endpackage

// File: rtl/sb_age_arb.sv
module sb_age_arb #(
    parameter int N    = 5,
    parameter int NSEL = 1,
    parameter int AW   = 4
) (
    input  logic [N-1:0]  req,
    input  logic [AW-1:0] age [N],
    output logic [N-1:0]  grant
);
    always_comb begin
        logic [N-1:0]  taken;
        logic          found;
        int            pick;
        logic [AW-1:0] best_age;
        taken = '0;
        for (int k = 0; k < NSEL; k++) begin
            found    = 1'b0;
            pick     = 0;
            best_age = '0;
            for (int i = 0; i < N; i++) begin
                if (req[i] && !taken[i] && (!found || age[i] > best_age)) begin
                    found    = 1'b1;
                    pick     = i;
                    best_age = age[i];
                end
            end
            if (found) taken[pick] = 1'b1;
        end
        grant = taken;
    end
endmodule

// File: rtl/sb_issue.sv
module sb_issue
    import sb_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           iss_valid,
    input  op_t            iss_op,
    input  reg_t           iss_dst,
    input  reg_t           iss_src1,
    input  reg_t           iss_src2,
    input  logic [NFU-1:0] busy,
    input  logic [NFU-1:0] wb_grant,
    output logic           iss_ready,
    output logic           iss_fire,
    output fu_t            iss_unit,
    output fu_t            qj,
    output fu_t            qk,
    output logic           qjv,
    output logic           qkv
);
    logic           rs_v [NREG];
    fu_t            rs_u [NREG];
    logic [NFU-1:0] free_mask;
    logic           any_free;

    always_comb begin
        iss_unit = '0;
        any_free = 1'b0;
        for (int u = NFU - 1; u >= 0; u--) begin
            free_mask[u] = !busy[u] && (unit_kind(u) == op_kind(iss_op));
            if (free_mask[u]) begin
                iss_unit = fu_t'(u);
                any_free = 1'b1;
            end
        end
    end

    assign iss_ready = any_free && !rs_v[iss_dst];
    assign iss_fire  = iss_valid && iss_ready;
    assign qj  = rs_u[iss_src1];
    assign qk  = rs_u[iss_src2];
    assign qjv = rs_v[iss_src1] && !wb_grant[rs_u[iss_src1]];
    assign qkv = rs_v[iss_src2] && !wb_grant[rs_u[iss_src2]];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int r = 0; r < NREG; r++) begin
                rs_v[r] <= 1'b0;
                rs_u[r] <= '0;
            end
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (rs_v[r] && wb_grant[rs_u[r]]) rs_v[r] <= 1'b0;
            end
            if (iss_fire) begin
                rs_v[iss_dst] <= 1'b1;
                rs_u[iss_dst] <= iss_unit;
            end
        end
    end

    // R2
    issue_claims_unit_chk: assert property (@(posedge clk) disable iff (rst)
        iss_fire |=> busy[$past(iss_unit)]);

    // R5
    issue_marks_dest_chk: assert property (@(posedge clk) disable iff (rst)
        iss_fire |=> !iss_ready || (iss_dst != $past(iss_dst)));
endmodule

// File: rtl/sb_fu_slot.sv
module sb_fu_slot
    import sb_pkg::*;
#(
    parameter int LAT = 2,
    parameter int CW  = 6
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            alloc,
    input  fu_rec_t         new_rec,
    input  logic [SEQW-1:0] tag_in,
    input  logic            rd_go,
    input  logic            wb_go,
    input  logic [NFU-1:0]  wb_any,
    output fu_rec_t         rec,
    output logic [SEQW-1:0] tag,
    output logic            rd_req,
    output logic            wb_req
);
    stage_t        stage;
    logic [CW-1:0] cnt;

    assign rd_req = rec.busy && stage == ST_READ && rec.rj && rec.rk;
    assign wb_req = rec.busy && stage == ST_WRITE;

    always_ff @(posedge clk) begin
        if (rst) begin
            rec   <= '0;
            stage <= ST_READ;
            cnt   <= '0;
            tag   <= '0;
        end else if (alloc) begin
            rec   <= new_rec;
            stage <= ST_READ;
            cnt   <= '0;
            tag   <= tag_in;
        end else if (rec.busy) begin
            if (rec.qjv && wb_any[rec.qj]) begin
                rec.qjv <= 1'b0;
                rec.rj  <= 1'b1;
            end
            if (rec.qkv && wb_any[rec.qk]) begin
                rec.qkv <= 1'b0;
                rec.rk  <= 1'b1;
            end
            case (stage)
                ST_READ: if (rd_go) begin
                    rec.rj <= 1'b0;
                    rec.rk <= 1'b0;
                    stage  <= ST_EXEC;
                    cnt    <= CW'(LAT);
                end
                ST_EXEC: if (cnt == CW'(1)) stage <= ST_WRITE;
                         else cnt <= cnt - 1'b1;
                ST_WRITE: if (wb_go) rec.busy <= 1'b0;
                default: ;
            endcase
        end
    end

    // R6
    read_only_when_ready_chk: assert property (@(posedge clk) disable iff (rst)
        rd_go |-> rd_req);

    // R7
    write_only_after_exec_chk: assert property (@(posedge clk) disable iff (rst)
        wb_go |-> wb_req);

    // R4
    write_frees_unit_chk: assert property (@(posedge clk) disable iff (rst)
        wb_go |=> !rec.busy);

    // R3
    exec_count_live_chk: assert property (@(posedge clk) disable iff (rst)
        (rec.busy && stage == ST_EXEC) |-> cnt != '0);
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl
    import sb_pkg::*;
#(
    parameter int RD_BUSES = 1,
    parameter int WR_BUSES = 1,
    parameter int LAT_INT  = 1,
    parameter int LAT_ADD  = 2,
    parameter int LAT_MUL  = 10,
    parameter int LAT_DIV  = 40
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          iss_valid,
    input  logic [2:0]    iss_op,
    input  logic [4:0]    iss_dst,
    input  logic [4:0]    iss_src1,
    input  logic [4:0]    iss_src2,
    output logic          iss_ready,
    output logic [2:0]    iss_unit,
    output logic [4:0]    rd_grant,
    output logic [4:0]    wb_grant
);
    localparam int MAXL01 = (LAT_INT > LAT_ADD) ? LAT_INT : LAT_ADD;
    localparam int MAXL23 = (LAT_MUL > LAT_DIV) ? LAT_MUL : LAT_DIV;
    localparam int MAXLAT = (MAXL01 > MAXL23) ? MAXL01 : MAXL23;
    localparam int CW     = $clog2(MAXLAT + 1);

    fu_rec_t         recs [NFU];
    logic [SEQW-1:0] tags [NFU];
    logic [SEQW-1:0] ages [NFU];
    logic [NFU-1:0]  busy, rd_req, wb_raw, war_hold;
    logic [SEQW-1:0] seq_cnt;
    logic            iss_fire, qjv, qkv;
    fu_t             unit_sel, qj, qk;
    fu_rec_t         new_rec;
    op_t             op_in;

    assign op_in    = op_t'(iss_op);
    assign iss_unit = unit_sel;

    sb_issue u_issue (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(op_in),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .busy(busy), .wb_grant(wb_grant), .iss_ready(iss_ready),
        .iss_fire(iss_fire), .iss_unit(unit_sel),
        .qj(qj), .qk(qk), .qjv(qjv), .qkv(qkv)
    );

    always_comb begin
        new_rec      = '0;
        new_rec.busy = 1'b1;
        new_rec.op   = op_in;
        new_rec.fi   = iss_dst;
        new_rec.fj   = iss_src1;
        new_rec.fk   = iss_src2;
        new_rec.qj   = qj;
        new_rec.qk   = qk;
        new_rec.qjv  = qjv;
        new_rec.qkv  = qkv;
        new_rec.rj   = !qjv;
        new_rec.rk   = !qkv;
    end

    always_ff @(posedge clk) begin
        if (rst) seq_cnt <= '0;
        else if (iss_fire) seq_cnt <= seq_cnt + 1'b1;
    end

    for (genvar u = 0; u < NFU; u++) begin : g_slot
        localparam kind_t KND = unit_kind(u);
        localparam int LAT = (KND == K_INT) ? LAT_INT :
                             (KND == K_ADD) ? LAT_ADD :
                             (KND == K_MUL) ? LAT_MUL : LAT_DIV;
        sb_fu_slot #(.LAT(LAT), .CW(CW)) u_slot (
            .clk(clk), .rst(rst),
            .alloc(iss_fire && unit_sel == fu_t'(u)),
            .new_rec(new_rec), .tag_in(seq_cnt),
            .rd_go(rd_grant[u]), .wb_go(wb_grant[u]), .wb_any(wb_grant),
            .rec(recs[u]), .tag(tags[u]),
            .rd_req(rd_req[u]), .wb_req(wb_raw[u])
        );
        assign busy[u] = recs[u].busy;
        assign ages[u] = seq_cnt - tags[u];
    end

    always_comb begin
        for (int u = 0; u < NFU; u++) begin
            war_hold[u] = 1'b0;
            for (int v = 0; v < NFU; v++) begin
                if (v != u && recs[v].busy &&
                    ((recs[v].fj == recs[u].fi && recs[v].rj) ||
                     (recs[v].fk == recs[u].fi && recs[v].rk)))
                    war_hold[u] = 1'b1;
            end
        end
    end

    sb_age_arb #(.N(NFU), .NSEL(RD_BUSES), .AW(SEQW)) u_rd_arb (
        .req(rd_req), .age(ages), .grant(rd_grant)
    );

    sb_age_arb #(.N(NFU), .NSEL(WR_BUSES), .AW(SEQW)) u_wb_arb (
        .req(wb_raw & ~war_hold), .age(ages), .grant(wb_grant)
    );

    // R8
    rd_bus_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rd_grant) <= RD_BUSES);

    // R8
    wb_bus_limit_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(wb_grant) <= WR_BUSES);

    // R5
    for (genvar a = 0; a < NFU; a++) begin : g_waw_a
        for (genvar b = a + 1; b < NFU; b++) begin : g_waw_b
            single_writer_chk: assert property (@(posedge clk) disable iff (rst)
                !(recs[a].busy && recs[b].busy && recs[a].fi == recs[b].fi));
        end
    end
endmodule

// File: tb/sb_ctrl_test.sv
`timescale 1ns/1ps
module sb_ctrl_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       iss_valid = 1'b0;
    logic [2:0] iss_op = '0;
    logic [4:0] iss_dst = '0, iss_src1 = '0, iss_src2 = '0;
    logic       iss_ready;
    logic [2:0] iss_unit;
    logic [4:0] rd_grant, wb_grant;

    int cyc = 0;
    int nchk = 0;
    int nfail = 0;
    int rd_cyc [5];
    int wb_cyc [5];

    // columns: op, dst, expected unit, expected issue-to-write distance
    localparam int VEC [5][4] = '{
        '{0, 1, 0, 3},
        '{1, 3, 3, 4},
        '{2, 4, 3, 4},
        '{3, 5, 1, 12},
        '{4, 6, 4, 42}
    };

    sb_ctrl uut (
        .clk(clk), .rst(rst), .iss_valid(iss_valid), .iss_op(iss_op),
        .iss_dst(iss_dst), .iss_src1(iss_src1), .iss_src2(iss_src2),
        .iss_ready(iss_ready), .iss_unit(iss_unit),
        .rd_grant(rd_grant), .wb_grant(wb_grant)
    );

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        for (int u = 0; u < 5; u++) begin
            if (rd_grant[u]) rd_cyc[u] = cyc;
            if (wb_grant[u]) wb_cyc[u] = cyc;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    endtask

    task automatic clear_marks();
        for (int u = 0; u < 5; u++) begin
            rd_cyc[u] = -1;
            wb_cyc[u] = -1;
        end
    endtask

    task automatic issue(input int op, input int d, input int s1, input int s2,
                         output int icyc, output int unit);
        @(negedge clk);
        iss_valid = 1'b1;
        iss_op = 3'(op); iss_dst = 5'(d); iss_src1 = 5'(s1); iss_src2 = 5'(s2);
        #1;
        while (!iss_ready) begin
            @(negedge clk);
            #1;
        end
        icyc = cyc;
        unit = int'(iss_unit);
        @(posedge clk);
        #1 iss_valid = 1'b0;
    endtask

    task automatic wait_wb(input int u, input int limit);
        int k = 0;
        while (wb_cyc[u] < 0 && k < limit) begin
            @(negedge clk);
            k++;
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (40000) @(posedge clk);
        nchk++;
        nfail++;
        $display("FAIL watchdog expired, run hung (R1..): got 0 expected 1");
        summary();
    end

    initial begin
        int ic, un, ia, ib, ic2;
        clear_marks();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 iss_ready", int'(iss_ready), 1);
        check("R1 rd_grant", int'(rd_grant), 0);
        check("R1 wb_grant", int'(wb_grant), 0);

        // R2 / R3 isolated instructions, table-driven
        for (int i = 0; i < 5; i++) begin
            clear_marks();
            issue(VEC[i][0], VEC[i][1], 30, 31, ic, un);
            check("R2 unit choice", un, VEC[i][2]);
            wait_wb(VEC[i][2], 80);
            check("R3 write latency", wb_cyc[VEC[i][2]] - ic, VEC[i][3]);
            settle();
        end

        // R4 structural stall on the multiply class
        clear_marks();
        issue(3, 1, 30, 31, ia, un);
        check("R2 first multiplier", un, 1);
        issue(3, 2, 30, 31, ib, un);
        check("R2 second multiplier", un, 2);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = 3'd3; iss_dst = 5'd3;
        #1 check("R4 stall while multipliers busy", int'(iss_ready), 0);
        issue(3, 3, 30, 31, ic, un);
        check("R4 accepted after first write", ic, wb_cyc[1] + 1);
        check("R4 reuses freed unit", un, 1);
        wait_wb(1, 80);
        settle();

        // R5 WAW stall
        clear_marks();
        issue(4, 7, 30, 31, ia, un);
        @(negedge clk);
        iss_valid = 1'b1; iss_op = 3'd0; iss_dst = 5'd7;
        #1 check("R5 stall on pending writer", int'(iss_ready), 0);
        issue(0, 7, 30, 31, ic, un);
        check("R5 accepted after writer", ic, wb_cyc[4] + 1);
        wait_wb(0, 20);
        settle();

        // R6 RAW wait
        clear_marks();
        issue(0, 2, 30, 31, ia, un);
        issue(1, 8, 2, 4, ib, un);
        wait_wb(3, 40);
        check("R6 read after producer", rd_cyc[3], wb_cyc[0] + 1);
        settle();

        // R8 oldest wins the read bus: adder issued before multiplier
        clear_marks();
        issue(0, 2, 30, 31, ia, un);
        issue(1, 8, 2, 4, ib, un);
        issue(3, 9, 2, 4, ic2, un);
        wait_wb(1, 60);
        check("R8 older adder reads first", rd_cyc[3], wb_cyc[0] + 1);
        check("R8 younger multiplier next", rd_cyc[1], wb_cyc[0] + 2);
        settle();

        // R8 same contention with the order reversed
        clear_marks();
        issue(0, 2, 30, 31, ia, un);
        issue(3, 9, 2, 4, ib, un);
        issue(1, 8, 2, 4, ic2, un);
        wait_wb(1, 60);
        check("R8 older multiplier reads first", rd_cyc[1], wb_cyc[0] + 1);
        check("R8 younger adder next", rd_cyc[3], wb_cyc[0] + 2);
        settle();

        // R6 / R7 WAR hold on the adder's write
        clear_marks();
        issue(3, 0, 2, 4, ia, un);
        issue(4, 10, 0, 6, ib, un);
        issue(1, 6, 8, 2, ic2, un);
        wait_wb(4, 120);
        check("R6 divider reads after multiply write", rd_cyc[4], wb_cyc[1] + 1);
        check("R7 adder write waits for old read", wb_cyc[3], rd_cyc[4] + 1);
        settle();

        summary();
    end
endmodule